// File: doc/BRIEF.md
# Programmable 16-bit Timer Channel

The block is one 16-bit timer channel for a system-on-chip timer bank. Software reaches it through three registers on a small synchronous bus: the running count, a mode register, and a compare (target) value. The count advances on a clock enable picked by the mode register. That enable is either every system clock, or a slower tick whose source depends on which channel the instance is. The channel number is a parameter. Channel 0 can run from a pixel-rate tick. Channel 1 can run from a once-per-scanline tick. Channel 2 has a divide-by-eight prescaler and a stop control.

The count either returns to zero when it reaches the target or runs on to full scale. Either event sets sticky status bits in the mode register. Either event can also request an interrupt, once per arming or on every event. The request is a one-cycle pulse on one lane of an interrupt vector that goes to an external interrupt controller, and the lane is fixed by the channel number. Reading the mode register returns the status and then clears the two event flags. Writing the mode register restarts the channel from zero and re-arms the one-shot interrupt.

Top module: `tmr16_channel`

## Requirements
- R1: After reset the count, mode and target registers read 0 and no interrupt lane is active.
- R2: Register addresses are 0 = count, 1 = mode, 2 = target. Address 3 reads 0 and ignores writes. Read data is registered: it shows the value from before the strobe edge in the cycle after the read strobe. A count write loads the 16-bit write data.
- R3: The count rises by one on every enabled tick. When the system clock is the source, it rises once per clock.
- R4: A target write replaces the compare value and leaves the count running undisturbed.
- R5: When the count would become equal to the target and mode bit 3 is set, it becomes 0 instead. When bit 3 is clear, the count takes the target value and keeps counting.
- R6: When the count would become 0xFFFF, it becomes 0 instead. This happens whatever the mode.
- R7: A target match sets mode bit 11. A full-scale event sets mode bit 12. Either event sets mode bit 10. All three bits stay set until cleared.
- R8: A mode read returns the whole register and then clears bits 11 and 12, leaving bit 10. If an event happens in the same cycle as the read, the flag it sets survives the clear.
- R9: A mode write stores write bits 9..0, clears bits 12..10, forces the count to 0, re-arms the one-shot interrupt and restarts the tick dividers. Bits 15..13 always read 0.
- R10: Mode bit 4 enables an interrupt on a target match, and mode bit 5 enables one on a full-scale event. The interrupt is a one-cycle pulse on `irq_bits` bit 4+CHAN (0x10, 0x20 or 0x40). It appears in the cycle after the edge that processes the event, and no other lane is ever driven.
- R11: With mode bit 6 clear, only the first enabled event after a mode write pulses the interrupt. With bit 6 set, every enabled event pulses it.
- R12: Mode bit 8 selects the alternate tick. On channel 0 it is one tick every PIX_DIV clocks, and on channel 1 one tick every LINE_DIV clocks. The first tick comes PIX_DIV or LINE_DIV clocks after the mode write. Bits 0 and 9 have no effect on channels 0 and 1.
- R13: On channel 2, mode bit 9 selects one tick every PRE_DIV clocks. Mode bit 0 stops counting, but count writes still load. Bit 8 has no effect on channel 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 count, 1 mode, 2 target |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_rd | input | 1 | Read strobe; a mode read also clears the event flags |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_bits | output | IRQ_W | Interrupt request vector; only lane 4+CHAN ever pulses |

## Verification
The hardest case to reach from the ports is a mode read that lands on the same edge as a target match. If the clear took priority, the event would be lost without trace. The stimulus writes the mode register, which puts the count at a known 0. It then waits exactly target-1 idle cycles, so the read strobe falls on the matching edge. The next two reads must show the flag appearing and then clearing. The one-shot re-arm is reached the same way: the bench lets the count pass the target twice, rewrites the mode register, and counts the pulses in each window.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 2;
    localparam int LANE_BASE = 4;

    localparam logic [DATA_W-1:0] FULL_SCALE = 16'hFFFF;

    typedef enum logic [ADDR_W-1:0] {
        REG_COUNT  = 2'd0,
        REG_MODE   = 2'd1,
        REG_TARGET = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    // Layout of the mode/status register, most significant bit first.
    typedef struct packed {
        logic [2:0] pad_z;       // 15..13 always zero
        logic       flag_full;   // 12 full-scale seen
        logic       flag_tgt;    // 11 target seen
        logic       flag_any;    // 10 any event seen
        logic       sel_hi;      // 9  prescale select (channel 2)
        logic       sel_lo;      // 8  alternate tick (channels 0, 1)
        logic       spare7;      // 7
        logic       irq_repeat;  // 6
        logic       irq_full_en; // 5
        logic       irq_tgt_en;  // 4
        logic       wrap_tgt;    // 3
        logic [1:0] spare21;     // 2..1
        logic       sel_b0;      // 0  stop (channel 2)
    } mode_t;

    typedef struct packed {
        logic [DATA_W-1:0] nxt;
        logic              tgt_hit;
        logic              full_hit;
    } step_res_t;

    // Only the control field of a written word is kept; status and pad clear.
    function automatic mode_t mode_from_bus(input logic [DATA_W-1:0] d);
        mode_t m;
        m          = mode_t'(d);
        m.pad_z    = '0;
        m.flag_full = 1'b0;
        m.flag_tgt  = 1'b0;
        m.flag_any  = 1'b0;
        return m;
    endfunction

    // Outcome of one counting step from the current value.
    function automatic step_res_t eval_step(input logic [DATA_W-1:0] cur,
                                            input logic [DATA_W-1:0] tgt,
                                            input logic              wrap_en);
        step_res_t         r;
        logic [DATA_W-1:0] inc;
        inc        = cur + 1'b1;
        r.tgt_hit  = (inc == tgt);
        r.full_hit = (inc == FULL_SCALE);
        r.nxt      = (r.full_hit || (wrap_en && r.tgt_hit)) ? '0 : inc;
        return r;
    endfunction

    function automatic int lane_of(input int chan);
        return LANE_BASE + chan;
    endfunction

endpackage

// File: rtl/tmr16_divider.sv
module tmr16_divider #(
    parameter int DIV = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic pulse
);
    localparam int            CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign pulse = (phase_q == LAST);

endmodule

// File: rtl/tmr16_tick_gen.sv
module tmr16_tick_gen #(
    parameter int CHAN     = 0,
    parameter int PIX_DIV  = 5,
    parameter int LINE_DIV = 2150,
    parameter int PRE_DIV  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic sel_b0,
    input  logic sel_lo,
    input  logic sel_hi,
    output logic tick
);
    logic alt_tick;

    generate
        if (CHAN == 0) begin : g_pix
            tmr16_divider #(.DIV(PIX_DIV)) u_div (
                .clk(clk), .rst(rst), .restart(restart), .pulse(alt_tick)
            );
            logic unused_sel;
            assign unused_sel = &{1'b0, sel_b0, sel_hi};
            assign tick = sel_lo ? alt_tick : 1'b1;
        end else if (CHAN == 1) begin : g_line
            tmr16_divider #(.DIV(LINE_DIV)) u_div (
                .clk(clk), .rst(rst), .restart(restart), .pulse(alt_tick)
            );
            logic unused_sel;
            assign unused_sel = &{1'b0, sel_b0, sel_hi};
            assign tick = sel_lo ? alt_tick : 1'b1;
        end else if (CHAN == 2) begin : g_pre
            tmr16_divider #(.DIV(PRE_DIV)) u_div (
                .clk(clk), .rst(rst), .restart(restart), .pulse(alt_tick)
            );
            logic unused_sel;
            assign unused_sel = &{1'b0, sel_lo};
            assign tick = sel_b0 ? 1'b0 : (sel_hi ? alt_tick : 1'b1);
        end else begin : g_plain
            logic unused_sel;
            assign unused_sel = &{1'b0, clk, rst, restart, sel_b0, sel_lo, sel_hi};
            assign alt_tick   = 1'b1;
            assign tick       = alt_tick;
        end
    endgenerate

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              cnt_wr,
    input  logic              mode_wr,
    input  logic              mode_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] target,
    output logic [DATA_W-1:0] cnt,
    output mode_t             mode,
    output logic              fired,
    output logic              irq_pulse
);
    logic [DATA_W-1:0] cnt_q;
    mode_t             mode_q;
    logic              fired_q;
    logic              irq_q;

    logic      step;
    step_res_t res;
    logic      want_irq;
    logic      fire;

    // A bus write to count or mode owns the edge; no step is taken then.
    assign step     = tick & ~cnt_wr & ~mode_wr;
    assign res      = eval_step(cnt_q, target, mode_q.wrap_tgt);
    assign want_irq = step & ((res.tgt_hit  & mode_q.irq_tgt_en) |
                              (res.full_hit & mode_q.irq_full_en));
    assign fire     = want_irq & (mode_q.irq_repeat | ~fired_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (mode_wr) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= wdata;
        end else if (step) begin
            cnt_q <= res.nxt;
        end
    end

    // Event flags: the clear from a read and the set from a step on the
    // same edge resolve in favour of the set.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (mode_wr) begin
            mode_q <= mode_from_bus(wdata);
        end else begin
            mode_q.flag_tgt  <= (mode_q.flag_tgt  & ~mode_rd) | (step & res.tgt_hit);
            mode_q.flag_full <= (mode_q.flag_full & ~mode_rd) | (step & res.full_hit);
            mode_q.flag_any  <= mode_q.flag_any | (step & (res.tgt_hit | res.full_hit));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || mode_wr) begin
            fired_q <= 1'b0;
        end else if (fire) begin
            fired_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= fire;
        end
    end

    assign cnt       = cnt_q;
    assign mode      = mode_q;
    assign fired     = fired_q;
    assign irq_pulse = irq_q;

endmodule

// File: rtl/tmr16_channel.sv
module tmr16_channel
    import tmr16_pkg::*;
#(
    parameter int CHAN     = 0,
    parameter int PIX_DIV  = 5,
    parameter int LINE_DIV = 2150,
    parameter int PRE_DIV  = 8,
    parameter int IRQ_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [15:0]      bus_wdata,
    output logic [15:0]      bus_rdata,
    output logic [IRQ_W-1:0] irq_bits
);
    localparam int IRQ_BIT = lane_of(CHAN);

    reg_sel_e sel;
    logic     cnt_wr, mode_wr, tgt_wr, mode_rd;

    logic [DATA_W-1:0] tgt_q;
    logic [DATA_W-1:0] cnt_q;
    mode_t             mode_q;
    logic              fired_w;
    logic              tick_w;
    logic              irq_pulse;
    logic [DATA_W-1:0] rd_mux;

    assign sel     = reg_sel_e'(bus_addr);
    assign cnt_wr  = bus_wr && (sel == REG_COUNT);
    assign mode_wr = bus_wr && (sel == REG_MODE);
    assign tgt_wr  = bus_wr && (sel == REG_TARGET);
    assign mode_rd = bus_rd && !bus_wr && (sel == REG_MODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q <= '0;
        end else if (tgt_wr) begin
            tgt_q <= bus_wdata;
        end
    end

    tmr16_tick_gen #(
        .CHAN(CHAN), .PIX_DIV(PIX_DIV), .LINE_DIV(LINE_DIV), .PRE_DIV(PRE_DIV)
    ) u_tick (
        .clk(clk), .rst(rst), .restart(mode_wr),
        .sel_b0(mode_q.sel_b0), .sel_lo(mode_q.sel_lo), .sel_hi(mode_q.sel_hi),
        .tick(tick_w)
    );

    tmr16_core u_core (
        .clk(clk), .rst(rst), .tick(tick_w),
        .cnt_wr(cnt_wr), .mode_wr(mode_wr), .mode_rd(mode_rd),
        .wdata(bus_wdata), .target(tgt_q),
        .cnt(cnt_q), .mode(mode_q), .fired(fired_w), .irq_pulse(irq_pulse)
    );

    always_comb begin
        case (sel)
            REG_COUNT:  rd_mux = cnt_q;
            REG_MODE:   rd_mux = mode_q;
            REG_TARGET: rd_mux = tgt_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    generate
        for (genvar i = 0; i < IRQ_W; i++) begin : g_lane
            if (i == IRQ_BIT) begin : g_on
                assign irq_bits[i] = irq_pulse;
            end else begin : g_off
                assign irq_bits[i] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/tmr16_checker.sv
module tmr16_checker #(
    parameter int CHAN  = 0,
    parameter int IRQ_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [15:0]      bus_wdata,
    input logic [IRQ_W-1:0] irq_bits,
    input logic [15:0]      cnt,
    input logic [15:0]      mode_raw,
    input logic [15:0]      target,
    input logic             fired,
    input logic             tick
);
    localparam logic [IRQ_W-1:0] LANE = IRQ_W'(1) << (4 + CHAN);
    localparam logic             IS_STOP_CHAN = (CHAN == 2);

    AST_IRQ_LANE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_bits) && ((irq_bits & ~LANE) == '0)); // R10

    AST_ONESHOT: assert property (@(posedge clk) disable iff (rst)
        (fired && !mode_raw[6] && !(bus_wr && bus_addr == 2'd1)) |=> (irq_bits == '0)); // R11

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0) |=> (cnt == $past(bus_wdata))); // R2

    AST_MODE_WR_CLR: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd1) |=> (cnt == 16'd0 && mode_raw[12:10] == 3'd0 && !fired)); // R9

    AST_RD_CLR: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == 2'd1 && !tick) |=> (mode_raw[12:11] == 2'd0)); // R8

    AST_TGT_KEEP: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd2 && !tick) |=> $stable(cnt)); // R4

    AST_STOP: assert property (@(posedge clk) disable iff (rst)
        (IS_STOP_CHAN && mode_raw[0] && !bus_wr) |=> $stable(cnt)); // R13

    AST_WRAP_TGT: assert property (@(posedge clk) disable iff (rst)
        (tick && !bus_wr && mode_raw[3] && (cnt + 16'd1 == target)) |=> (cnt == 16'd0)); // R5

    AST_FULL_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && !bus_wr && cnt == 16'hFFFE) |=> (cnt == 16'd0 && mode_raw[12])); // R6

endmodule

bind tmr16_channel tmr16_checker #(.CHAN(CHAN), .IRQ_W(IRQ_W)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .irq_bits(irq_bits), .cnt(cnt_q), .mode_raw(mode_q),
    .target(tgt_q), .fired(fired_w), .tick(tick_w)
);

// File: tb/tb_tmr16_channel.sv
module tb_tmr16_channel;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [1:0]  addr  = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [2:0]  wr    = 3'b000;
    logic [2:0]  rd    = 3'b000;
    logic [2:0]  rd_d  = 3'b000;
    logic [15:0] rdata [3];
    logic [7:0]  irqv  [3];

    tmr16_channel #(.CHAN(0)) dut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr[0]), .bus_rd(rd[0]),
        .bus_wdata(wdata), .bus_rdata(rdata[0]), .irq_bits(irqv[0]));

    tmr16_channel #(.CHAN(1), .LINE_DIV(16)) dut_c1 (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr[1]), .bus_rd(rd[1]),
        .bus_wdata(wdata), .bus_rdata(rdata[1]), .irq_bits(irqv[1]));

    tmr16_channel #(.CHAN(2)) dut_c2 (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr[2]), .bus_rd(rd[2]),
        .bus_wdata(wdata), .bus_rdata(rdata[2]), .irq_bits(irqv[2]));

    typedef struct {
        int          unit;
        logic [15:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    int n_tests  = 0;
    int n_fail   = 0;
    int irq_cnt [3] = '{0, 0, 0};
    int lane_err = 0;
    bit done     = 1'b0;

    always @(posedge clk) rd_d <= rd;

    // Scoreboard monitor: read results appear the cycle after the strobe.
    always @(negedge clk) begin
        for (int u = 0; u < 3; u++) begin
            if (rd_d[u]) begin
                exp_item_t it;
                n_tests++;
                if (sb_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R2: unexpected read data %h on unit %0d", rdata[u], u);
                end else begin
                    it = sb_q.pop_front();
                    if (it.unit != u || rdata[u] !== it.exp) begin
                        n_fail++;
                        $display("FAIL %s: unit %0d got %h expected %h", it.tag, u, rdata[u], it.exp);
                    end
                end
            end
        end
    end

    // Interrupt monitor: counts pulses and checks the lane of each.
    always @(negedge clk) begin
        for (int u = 0; u < 3; u++) begin
            if (!rst && irqv[u] != 8'h00) begin
                irq_cnt[u]++;
                if (irqv[u] != (8'h10 << u)) begin
                    lane_err++;
                    $display("FAIL R10: unit %0d lanes %h expected %h", u, irqv[u], 8'h10 << u);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input int u, input logic [1:0] a, input logic [15:0] d);
        addr  = a;
        wdata = d;
        wr[u] = 1'b1;
        @(negedge clk);
        wr[u] = 1'b0;
    endtask

    task automatic bus_read(input int u, input logic [1:0] a, input logic [15:0] e, input string tag);
        exp_item_t it;
        it.unit = u;
        it.exp  = e;
        it.tag  = tag;
        sb_q.push_back(it);
        addr  = a;
        rd[u] = 1'b1;
        @(negedge clk);
        rd[u] = 1'b0;
    endtask

    task automatic check(input logic [31:0] got, input logic [31:0] e, input string tag);
        n_tests++;
        if (got !== e) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        finish_run();
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        bus_read(0, 2'd0, 16'h0000, "R1 count after reset");
        bus_read(0, 2'd1, 16'h0000, "R1 mode after reset");
        bus_read(0, 2'd2, 16'h0000, "R1 target after reset");
        bus_read(0, 2'd3, 16'h0000, "R2 unused address");
        check(irq_cnt[0], 0, "R1 no interrupt after reset");

        // R3: system clock counting
        bus_write(0, 2'd1, 16'h0000);
        idle(10);
        bus_read(0, 2'd0, 16'd10, "R3 count per clock");

        // R2: count load
        bus_write(0, 2'd0, 16'h1234);
        idle(5);
        bus_read(0, 2'd0, 16'h1239, "R2 count load then run");

        // R4: target write keeps count
        bus_write(0, 2'd1, 16'h0000);
        idle(4);
        bus_write(0, 2'd2, 16'h0100);
        bus_read(0, 2'd0, 16'd5, "R4 count unchanged by target write");
        bus_read(0, 2'd2, 16'h0100, "R4 target readback");

        // R5 R7 R10 R11: wrap at target, one-shot interrupt
        bus_write(0, 2'd2, 16'd10);
        base = irq_cnt[0];
        bus_write(0, 2'd1, 16'h0018);
        idle(9);
        check(irqv[0], 8'h00, "R10 no pulse before event");
        idle(1);
        check(irqv[0], 8'h10, "R10 pulse cycle after target edge");
        idle(15);
        bus_read(0, 2'd0, 16'd5, "R5 wrap at target");
        bus_read(0, 2'd1, 16'h0C18, "R7 target flags set");
        bus_read(0, 2'd1, 16'h0418, "R8 read clears bit 11 keeps bit 10");
        check(irq_cnt[0] - base, 1, "R11 one-shot fires once");

        // R11: repeat mode
        base = irq_cnt[0];
        bus_write(0, 2'd1, 16'h0058);
        idle(35);
        check(irq_cnt[0] - base, 3, "R11 repeat fires every match");

        // R9: mode write re-arms one-shot
        base = irq_cnt[0];
        bus_write(0, 2'd1, 16'h0018);
        idle(25);
        check(irq_cnt[0] - base, 1, "R9 one-shot re-armed by mode write");

        // R8: read on the same edge as a target match
        bus_write(0, 2'd1, 16'h0008);
        idle(9);
        bus_read(0, 2'd1, 16'h0008, "R8 read on match edge returns old");
        bus_read(0, 2'd1, 16'h0C08, "R8 flag set survives same-edge clear");
        bus_read(0, 2'd1, 16'h0408, "R8 flag cleared by next read");

        // R6 R7 R5: full-scale wrap, target passed without bit 3
        bus_write(0, 2'd2, 16'd5);
        base = irq_cnt[0];
        bus_write(0, 2'd1, 16'h0020);
        bus_write(0, 2'd0, 16'hFFF0);
        idle(20);
        bus_read(0, 2'd0, 16'd5, "R6 full-scale wrap then run past target");
        bus_read(0, 2'd1, 16'h1C20, "R7 full-scale and target flags");
        bus_read(0, 2'd1, 16'h0420, "R8 flags cleared after read");
        check(irq_cnt[0] - base, 1, "R10 overflow interrupt only");

        // R9: stored field and zero bits
        bus_write(0, 2'd1, 16'hFC00);
        bus_read(0, 2'd1, 16'h0000, "R9 status and pad bits not writable");
        bus_write(0, 2'd1, 16'hE3FF);
        bus_read(0, 2'd1, 16'h03FF, "R9 control field stored");

        // R12: channel 0 pixel tick, bits 0 and 9 inert
        bus_write(0, 2'd1, 16'h0100);
        idle(23);
        bus_read(0, 2'd0, 16'd4, "R12 channel 0 alternate tick");
        bus_write(0, 2'd1, 16'h0201);
        idle(6);
        bus_read(0, 2'd0, 16'd6, "R12 channel 0 ignores bits 0 and 9");

        // R12: channel 1 scanline tick
        bus_write(1, 2'd1, 16'h0100);
        idle(40);
        bus_read(1, 2'd0, 16'd2, "R12 channel 1 alternate tick");
        bus_write(1, 2'd1, 16'h0201);
        idle(10);
        bus_read(1, 2'd0, 16'd10, "R12 channel 1 ignores bits 0 and 9");

        // R13: channel 2 prescaler and stop
        bus_write(2, 2'd1, 16'h0200);
        idle(20);
        bus_read(2, 2'd0, 16'd2, "R13 channel 2 divide by eight");
        bus_write(2, 2'd1, 16'h0001);
        idle(10);
        bus_read(2, 2'd0, 16'd0, "R13 channel 2 stopped");
        bus_write(2, 2'd0, 16'h0042);
        idle(5);
        bus_read(2, 2'd0, 16'h0042, "R13 stopped count still loads");
        bus_write(2, 2'd1, 16'h0100);
        idle(7);
        bus_read(2, 2'd0, 16'd7, "R13 channel 2 ignores bit 8");

        // R10: lanes of channels 1 and 2
        bus_write(1, 2'd2, 16'd3);
        base = irq_cnt[1];
        bus_write(1, 2'd1, 16'h0018);
        idle(6);
        check(irq_cnt[1] - base, 1, "R10 channel 1 interrupt");
        bus_write(2, 2'd2, 16'd3);
        base = irq_cnt[2];
        bus_write(2, 2'd1, 16'h0018);
        idle(6);
        check(irq_cnt[2] - base, 1, "R10 channel 2 interrupt");
        check(lane_err, 0, "R10 lane position");

        idle(3);
        check(sb_q.size(), 0, "R2 all reads answered");
        finish_run();
    end

endmodule